// File: doc/BRIEF.md
# Interval Timer Channel

This block is one channel of a legacy-compatible interval timer. It holds a 16-bit down-counter that advances only on a count-enable pulse (`tick_i`) in the system clock domain, and drives a single output pin whose waveform depends on one of six operating modes: a single timeout, a gate-triggered one-shot, a rate generator, a square-wave generator and software- or gate-triggered strobes. Counting is done in plain binary or in four BCD digits.

A separate bus block decodes the host accesses, sequences the bytes and latches counts. It hands this channel a one-cycle load strobe carrying the full initial count, the mode code and the BCD select. The channel reports the live count, the pin level and a flag that reads high while a programmed count is loaded and has not expired.

Top module: `pit_channel`

## Requirements
- R1: After reset `count_o` is 0, `out_o` is 1 and `loaded_o` is 0. Nothing counts until a load has been made.
- R2: A load strobe sets `out_o` to its starting level on the next clock: 0 for mode 0 and 1 for every other mode. The count is placed in the counter on the first later clock that has `tick_i` high. While `tick_i` is low the count does not change.
- R3: Mode 0 (code 000). The count decrements on each tick while `gate_i` is 1 and holds while `gate_i` is 0. `out_o` stays 0 from the load until the tick that brings the count to 0. That tick drives it to 1, and the count then holds at 0.
- R4: Mode 1 (code 001). A rising edge on `gate_i` arms the channel. The next tick loads the count and drives `out_o` to 0. The count then runs on every tick whatever the gate does. `out_o` returns to 1 on the tick that reaches 0.
- R5: Mode 2 (code 010). The channel repeats with a period of N ticks. `out_o` goes to 0 on the tick that brings the count to 1, and back to 1 on the next tick, which also reloads N. A low gate halts counting and forces `out_o` to 1. A rising gate reloads N on the next tick.
- R6: Mode 3 (code 011). The count falls by 2 on each tick, and the output toggles once per half period. For even N, `out_o` is high for N/2 ticks and low for N/2 ticks. For odd N, it is high for (N+1)/2 ticks and low for (N-1)/2 ticks. A low gate halts counting and forces `out_o` to 1.
- R7: Mode 4 (code 100). `out_o` stays 1 until the tick that brings the count to 0. It is then 0 for exactly one tick. The count holds at 0 with no reload.
- R8: Mode 5 (code 101). The channel behaves like mode 4, but the countdown is armed by a rising gate and then ignores the gate level.
- R9: The unused mode codes 110 and 111 behave exactly as codes 010 and 011.
- R10: With `bcd_i` = 1 the count is four BCD digits (bits 15:12 most significant). A digit at 0 wraps to 9 with a borrow, and the step of 2 in mode 3 obeys the same rule. With `bcd_i` = 0 the count is plain binary.
- R11: An initial count of 0 is the largest count. The first decrement gives 0xFFFF in binary and 0x9999 in BCD.
- R12: `loaded_o` is set by a load and stays 1 in modes 2 and 3. In modes 0, 1, 4 and 5 it clears on the tick that brings the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable pulse |
| load_i | input | 1 | One-cycle strobe that loads count, mode and BCD select |
| count_init_i | input | 16 | Initial count (0 = maximum) |
| mode_i | input | 3 | Operating mode code |
| bcd_i | input | 1 | 1 = BCD counting, 0 = binary |
| gate_i | input | 1 | Gate input |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Output pin level |
| loaded_o | output | 1 | Count loaded and not expired |

## Verification
The bench targets the odd-count asymmetry of the square wave. A design that split an odd count evenly, or put the extra tick in the low half, would shift every later toggle by one sample. It also covers the BCD borrow from 10 to 09 and from 10 to 08. A channel that wrapped a digit to F or skipped the borrow would show a wrong count or a shortened square-wave half period.

Further checks cover a gate that drops during a triggered one-shot, which a design that gated the count would stretch. They cover a low gate while the rate output is low, which a design without the forced-high rule would leave stuck low. They also check that the aliased mode codes, the zero-as-maximum count and the one-tick strobe pulses all land on the expected tick.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TIMEOUT  = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  // codes 11x fold onto 01x
  function automatic pit_mode_e pit_norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction

endpackage

// File: rtl/pit_decr.sv
module pit_decr #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] val_o
);
  localparam int DIG = W / 4;

  logic [DIG-1:0] brw;
  logic [W-1:0]   bcd_res;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIG; g++) begin : g_dig
    logic [3:0] d;
    assign d = val_i[4*g +: 4];
    assign bcd_res[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < DIG - 1) begin : g_chain
      assign brw[g+1] = brw[g] && (d == 4'd0);
    end
  end

  assign val_o = bcd_i ? bcd_res : val_i - {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i && !gate_q;
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  pit_mode_e    mode_i,
  input  logic         bcd_i,
  input  logic         gate_i,
  input  logic         rise_i,
  input  logic [W-1:0] dec1_i,
  input  logic [W-1:0] dec2_i,
  output logic [W-1:0] count_o,
  output logic         bcd_o,
  output logic         out_o,
  output logic         loaded_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  pit_mode_e    mode_q;
  logic [W-1:0] count_q, init_q, init_even;
  logic         bcd_q, out_q, loaded_q, run_q, prog_q;
  logic         arm_pend_q, pulse_q, odd_wait_q;
  logic         gate_free, level_gated, retrig;

  assign init_even   = {init_q[W-1:1], 1'b0};
  assign gate_free   = (mode_q == M_ONESHOT) || (mode_q == M_HWSTROBE);
  assign level_gated = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign retrig      = gate_free || level_gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_TIMEOUT;
      count_q    <= '0;
      init_q     <= '0;
      bcd_q      <= 1'b0;
      out_q      <= 1'b1;
      loaded_q   <= 1'b0;
      run_q      <= 1'b0;
      prog_q     <= 1'b0;
      arm_pend_q <= 1'b0;
      pulse_q    <= 1'b0;
      odd_wait_q <= 1'b0;
    end else if (load_i) begin
      mode_q     <= mode_i;
      bcd_q      <= bcd_i;
      init_q     <= init_i;
      prog_q     <= 1'b1;
      loaded_q   <= 1'b1;
      run_q      <= 1'b0;
      pulse_q    <= 1'b0;
      odd_wait_q <= 1'b0;
      out_q      <= (mode_i != M_TIMEOUT);
      arm_pend_q <= !((mode_i == M_ONESHOT) || (mode_i == M_HWSTROBE));
    end else begin
      if (rise_i && prog_q && retrig) arm_pend_q <= 1'b1;
      if (level_gated && !gate_i) out_q <= 1'b1;
      if (tick_i) begin
        if (pulse_q) begin
          out_q   <= 1'b1;
          pulse_q <= 1'b0;
        end
        if (arm_pend_q) begin
          count_q    <= (mode_q == M_SQUARE) ? init_even : init_q;
          run_q      <= 1'b1;
          arm_pend_q <= 1'b0;
          odd_wait_q <= 1'b0;
          loaded_q   <= 1'b1;
          out_q      <= !((mode_q == M_TIMEOUT) || (mode_q == M_ONESHOT));
        end else if (run_q && (gate_i || gate_free)) begin
          case (mode_q)
            M_TIMEOUT, M_ONESHOT: begin
              count_q <= dec1_i;
              if (count_q == ONE) begin
                out_q    <= 1'b1;
                run_q    <= 1'b0;
                loaded_q <= 1'b0;
              end
            end
            M_SWSTROBE, M_HWSTROBE: begin
              count_q <= dec1_i;
              if (count_q == ONE) begin
                out_q    <= 1'b0;
                pulse_q  <= 1'b1;
                run_q    <= 1'b0;
                loaded_q <= 1'b0;
              end
            end
            M_RATE: begin
              if (count_q == ONE) begin
                count_q <= init_q;
                out_q   <= 1'b1;
              end else begin
                count_q <= dec1_i;
                if (count_q == TWO) out_q <= 1'b0;
              end
            end
            M_SQUARE: begin
              if (odd_wait_q) begin
                count_q    <= init_even;
                out_q      <= !out_q;
                odd_wait_q <= 1'b0;
              end else if (count_q == TWO) begin
                // odd count: high half gets one extra tick
                if (out_q && init_q[0]) begin
                  count_q    <= '0;
                  odd_wait_q <= 1'b1;
                end else begin
                  count_q <= init_even;
                  out_q   <= !out_q;
                end
              end else begin
                count_q <= dec2_i;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign count_o  = count_q;
  assign bcd_o    = bcd_q;
  assign out_o    = out_q;
  assign loaded_o = loaded_q;

  assert_timeout_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode_q == M_TIMEOUT) |-> !out_q);

  assert_oneshot_gate_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ONESHOT && run_q && tick_i && !load_i && !arm_pend_q && !bcd_q && count_q > ONE)
      |=> (count_q == $past(count_q) - ONE));

  assert_gate_low_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_gated && !gate_i && !load_i) |=> out_q);

  assert_strobe_pulse_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !out_q);

  assert_expire_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_TIMEOUT && run_q && tick_i && gate_i && !load_i && !arm_pend_q && count_q == ONE)
      |=> (!loaded_o && out_o));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] count_init_i,
  input  logic [2:0]   mode_i,
  input  logic         bcd_i,
  input  logic         gate_i,
  output logic [W-1:0] count_o,
  output logic         out_o,
  output logic         loaded_o
);
  logic [W-1:0] dec1, dec2;
  logic         bcd_cur, rise;
  pit_mode_e    mode_n;

  assign mode_n = pit_norm_mode(mode_i);

  pit_gate_edge u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(gate_i),
    .rise_o(rise)
  );

  pit_decr #(.W(W)) u_dec1 (.val_i(count_o), .bcd_i(bcd_cur), .val_o(dec1));
  pit_decr #(.W(W)) u_dec2 (.val_i(dec1),    .bcd_i(bcd_cur), .val_o(dec2));

  pit_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .load_i  (load_i),
    .init_i  (count_init_i),
    .mode_i  (mode_n),
    .bcd_i   (bcd_i),
    .gate_i  (gate_i),
    .rise_i  (rise),
    .dec1_i  (dec1),
    .dec2_i  (dec2),
    .count_o (count_o),
    .bcd_o   (bcd_cur),
    .out_o   (out_o),
    .loaded_o(loaded_o)
  );
endmodule

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, load_i = 1'b0, bcd_i = 1'b0, gate_i = 1'b0;
  logic [15:0] count_init_i = '0;
  logic [2:0]  mode_i = '0;
  logic [15:0] count_o;
  logic        out_o, loaded_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pit_channel u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(load_i),
    .count_init_i(count_init_i), .mode_i(mode_i), .bcd_i(bcd_i), .gate_i(gate_i),
    .count_o(count_o), .out_o(out_o), .loaded_o(loaded_o)
  );

  // {mode, bcd, initial count, numeric N}
  localparam logic [31:0] VEC [11] = '{
    {4'd0, 4'd0, 16'h0005, 8'd5},
    {4'd0, 4'd1, 16'h0012, 8'd12},
    {4'd1, 4'd0, 16'h0004, 8'd4},
    {4'd2, 4'd0, 16'h0005, 8'd5},
    {4'd3, 4'd0, 16'h0006, 8'd6},
    {4'd3, 4'd0, 16'h0007, 8'd7},
    {4'd3, 4'd1, 16'h0011, 8'd11},
    {4'd4, 4'd0, 16'h0003, 8'd3},
    {4'd5, 4'd0, 16'h0004, 8'd4},
    {4'd6, 4'd0, 16'h0004, 8'd4},
    {4'd7, 4'd0, 16'h0005, 8'd5}
  };

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int x;
    r = '0;
    x = v;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic string req_of(input int m, input int raw, input int bcd);
    if (raw >= 6) return "R9";
    if (bcd != 0) return "R10";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic exp_out(input int m, input int n, input int k);
    case (m)
      0: return k >= n + 1;
      1: return !(k >= 2 && k < n + 2);
      2: return !(k >= n && (k % n) == 0);
      3: return (k == 0) || (((k - 1) % n) < (n + 1) / 2);
      4: return k != n + 1;
      default: return k != n + 2;
    endcase
  endfunction

  task automatic run_table();
    for (int i = 0; i < 11; i++) begin
      logic [31:0] v;
      int raw, m, n, bcd, k_exp, lim;
      string rq;
      v   = VEC[i];
      raw = int'(v[31:28]);
      bcd = int'(v[27:24]);
      n   = int'(v[7:0]);
      m   = (raw >= 6) ? raw - 4 : raw;
      rq  = req_of(m, raw, bcd);
      k_exp = (m == 1 || m == 5) ? n + 2 : n + 1;
      tick_i = 1'b1;
      gate_i = 1'b0;
      load_i = 1'b0;
      repeat (3) step();
      load_i = 1'b1;
      count_init_i = v[23:8];
      mode_i = v[30:28];
      bcd_i = v[24];
      gate_i = !(m == 1 || m == 5);
      step();
      load_i = 1'b0;
      gate_i = 1'b1;
      lim = 3 * n + 3;
      for (int k = 0; k < lim; k++) begin
        check(rq, 32'(out_o), 32'(exp_out(m, n, k)));
        if (k == 0) check("R2", 32'(out_o), 32'(m != 0));
        if (m == 2 || m == 3) check("R12", 32'(loaded_o), 32'h1);
        else check("R12", 32'(loaded_o), 32'(k < k_exp));
        if (m == 0 && k >= 1) begin
          if (k <= n + 1) check(rq, 32'(count_o), 32'(bcd != 0 ? to_bcd(n - k + 1) : 16'(n - k + 1)));
          else            check("R3", 32'(count_o), 32'h0);
        end
        if ((m == 4 || m == 5) && k >= k_exp) check(m == 4 ? "R7" : "R8", 32'(count_o), 32'h0);
        step();
      end
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    check("R1", 32'(count_o), 32'h0);
    check("R1", 32'(out_o), 32'h1);
    check("R1", 32'(loaded_o), 32'h0);
    tick_i = 1'b1;
    gate_i = 1'b1;
    repeat (4) step();
    check("R1", 32'(count_o), 32'h0);

    run_table();

    // R11: zero means maximum, binary then BCD
    for (int b = 0; b < 2; b++) begin
      tick_i = 1'b1;
      gate_i = 1'b1;
      load_i = 1'b1;
      count_init_i = 16'h0000;
      mode_i = 3'd0;
      bcd_i = b[0];
      step();
      load_i = 1'b0;
      step();
      check("R11", 32'(count_o), 32'h0);
      step();
      check("R11", 32'(count_o), b == 0 ? 32'hFFFF : 32'h9999);
    end

    // R2: load waits for a tick
    tick_i = 1'b0;
    held = count_o;
    load_i = 1'b1;
    count_init_i = 16'd3;
    mode_i = 3'd0;
    bcd_i = 1'b0;
    step();
    load_i = 1'b0;
    repeat (3) step();
    check("R2", 32'(count_o), 32'(held));
    check("R2", 32'(out_o), 32'h0);
    tick_i = 1'b1;
    step();
    check("R2", 32'(count_o), 32'd3);
    tick_i = 1'b0;
    repeat (2) step();
    check("R2", 32'(count_o), 32'd3);
    // R3: low gate holds mode 0
    tick_i = 1'b1;
    gate_i = 1'b0;
    repeat (3) step();
    check("R3", 32'(count_o), 32'd3);
    check("R3", 32'(out_o), 32'h0);
    gate_i = 1'b1;
    step();
    check("R3", 32'(count_o), 32'd2);

    // R4: gate drop does not stop mode 1
    gate_i = 1'b0;
    load_i = 1'b1;
    count_init_i = 16'd5;
    mode_i = 3'd1;
    step();
    load_i = 1'b0;
    gate_i = 1'b1;
    step();
    step();
    check("R4", 32'(out_o), 32'h0);
    gate_i = 1'b0;
    repeat (4) step();
    check("R4", 32'(out_o), 32'h0);
    check("R4", 32'(count_o), 32'd1);
    step();
    check("R4", 32'(out_o), 32'h1);

    // R5: low gate forces rate output high and halts it
    gate_i = 1'b1;
    load_i = 1'b1;
    count_init_i = 16'd4;
    mode_i = 3'd2;
    step();
    load_i = 1'b0;
    repeat (4) step();
    check("R5", 32'(out_o), 32'h0);
    gate_i = 1'b0;
    step();
    check("R5", 32'(out_o), 32'h1);
    repeat (2) step();
    check("R5", 32'(count_o), 32'd1);
    gate_i = 1'b1;
    repeat (2) step();
    check("R5", 32'(count_o), 32'd4);
    check("R5", 32'(out_o), 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule